// File: doc/BRIEF.md
# Consecutive-Fault Failover Flag Counter

This block watches the verdicts of a watchdog supervisor and decides when a redundant circuit should take over. The supervisor delivers two one-cycle strobes: one for a good heartbeat edge and one for a fault. A fault can be an early edge, a timeout, or any mix of the two. The supervisor also delivers a level flag that is high while the monitored supply is under voltage. The block drives one registered, active-low failover flag. The flag drops after a run of three faults with no good edge between them. It rises again only after a run of three good edges with no fault between them, so the flag has hysteresis in both directions.

Resets that come from the undervoltage monitor are not software failures. While the undervoltage flag is high, strobes are ignored, both runs restart from zero, and the failover flag is held released. The required run length is a parameter with a default of three. The block does no timing of the watchdog itself.

Top module: `failover_flag_ctl`

## Requirements
- R1: A synchronous active-high reset clears both runs and sets `failover_n` to 1 (released). Faults counted before a reset do not carry over after it.
- R2: When the third consecutive fault strobe is sampled, `failover_n` goes to 0 at that same clock edge, so it is low one cycle after the strobe is presented.
- R3: A good strobe clears the fault run. Two faults, a good edge, and then two more faults leave `failover_n` at 1.
- R4: Once `failover_n` is 0, it stays 0 through any number of further faults. It returns to 1 on the edge that samples the third consecutive good strobe.
- R5: A fault strobe in the middle of a good run restarts that run. While the flag is asserted, three new consecutive good strobes are then needed to release it.
- R6: While `uv` is 1, good and fault strobes are not counted, and both runs restart from zero. After `uv` falls, three fresh faults are needed to assert the flag.
- R7: On any clock edge that samples `uv` at 1, `failover_n` becomes 1. It is never 0 in the cycle after `uv` was 1.
- R8: A good strobe and a fault strobe in the same cycle are treated as a fault alone.
- R9: Both runs saturate at the run length. After many faults, exactly three good strobes release the flag. After many good strobes, exactly three faults assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| good_evt | input | 1 | One-cycle strobe: a good heartbeat edge was seen |
| fault_evt | input | 1 | One-cycle strobe: a watchdog fault (early edge or timeout) |
| uv | input | 1 | Undervoltage level flag, active high |
| failover_n | output | 1 | Registered failover flag, 0 = hand over to backup |

## Verification
The bench targets runs that are broken one short of three in each direction, where an off-by-one counter would assert or release a cycle early or late. It also checks good and fault strobes arriving in the same cycle: a design that lets the good strobe win would never assert under a persistent fault pattern. Undervoltage pulses in the middle of a run are covered, since a design that merely freezes the counters would assert after fewer fresh faults. Long saturating runs are covered too, since a counter that wraps would demand extra good edges or would release spontaneously.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic {
    FLAG_ASSERTED = 1'b0,
    FLAG_RELEASED = 1'b1
  } flag_level_e;
endpackage

// File: rtl/ffc_run_counter.sv
module ffc_run_counter #(
  parameter int RUN_LEN = 3,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             run_done
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  // run_done: this increment reaches (or holds) the full run length
  assign run_done = inc && !clr && (count >= LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && count != TOP) begin
      count <= count + 1'b1;
    end
  end

  // R9: the run counter saturates and never passes the run length
  a_r9_count_saturates: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);
  // R9: once full, further increments keep it full
  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && inc && !clr) |=> count == TOP);
endmodule

// File: rtl/ffc_flag_reg.sv
module ffc_flag_reg
  import ffc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold_off,
  input  logic set_fail,
  input  logic set_ok,
  output logic flag_n
);
  flag_level_e level_q;

  always_ff @(posedge clk) begin
    if (rst || hold_off) begin
      level_q <= FLAG_RELEASED;
    end else if (set_fail) begin
      level_q <= FLAG_ASSERTED;
    end else if (set_ok) begin
      level_q <= FLAG_RELEASED;
    end
  end

  assign flag_n = level_q;

  // R7: a hold-off request always leaves the flag released
  a_r7_holdoff_releases: assert property (@(posedge clk) disable iff (rst)
    hold_off |=> flag_n);
  // R2: the flag only drops when a full fault run is reported
  a_r2_drop_needs_fault_run: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_n) |-> $past(set_fail));
endmodule

// File: rtl/failover_flag_ctl.sv
module failover_flag_ctl #(
  parameter int RUN_LEN = 3,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic good_evt,
  input  logic fault_evt,
  input  logic uv,
  output logic failover_n
);
  logic             fault_ok;
  logic             good_ok;
  logic [CNT_W-1:0] fault_cnt;
  logic [CNT_W-1:0] good_cnt;
  logic             fault_run_done;
  logic             good_run_done;

  // R6: strobes during undervoltage are dropped; R8: fault wins a tie
  assign fault_ok = fault_evt && !uv;
  assign good_ok  = good_evt && !fault_evt && !uv;

  // fault run: restarted by a good edge (R3) or undervoltage (R6)
  ffc_run_counter #(.RUN_LEN(RUN_LEN)) u_fault_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (uv || good_ok),
    .inc      (fault_ok),
    .count    (fault_cnt),
    .run_done (fault_run_done)
  );

  // good run: restarted by any fault (R5) or undervoltage (R6)
  ffc_run_counter #(.RUN_LEN(RUN_LEN)) u_good_run (
    .clk      (clk),
    .rst      (rst),
    .clr      (uv || fault_evt),
    .inc      (good_ok),
    .count    (good_cnt),
    .run_done (good_run_done)
  );

  ffc_flag_reg u_flag (
    .clk      (clk),
    .rst      (rst),
    .hold_off (uv),
    .set_fail (fault_run_done),
    .set_ok   (good_run_done),
    .flag_n   (failover_n)
  );

  // R7: undervoltage in one cycle means released in the next
  a_r7_uv_keeps_released: assert property (@(posedge clk) disable iff (rst)
    uv |=> failover_n);
  // R4: an asserted flag survives further faults
  a_r4_stays_on_fault: assert property (@(posedge clk) disable iff (rst)
    (!failover_n && fault_evt && !uv) |=> !failover_n);
  // R4: release needs a counted good edge or undervoltage
  a_r4_release_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(failover_n) |-> $past(uv || (good_evt && !fault_evt)));
  // R8: a tied strobe never releases the flag
  a_r8_tie_not_good: assert property (@(posedge clk) disable iff (rst)
    (!failover_n && good_evt && fault_evt) |=> !failover_n || $past(uv));
  // R3: a counted good edge empties the fault run
  a_r3_good_clears_faults: assert property (@(posedge clk) disable iff (rst)
    (good_evt && !fault_evt) |=> fault_cnt == '0);
  // R5: a fault empties the good run
  a_r5_fault_clears_goods: assert property (@(posedge clk) disable iff (rst)
    fault_evt |=> good_cnt == '0);
endmodule

// File: tb/failover_flag_ctl_test.sv
module failover_flag_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic good_evt = 1'b0;
  logic fault_evt = 1'b0;
  logic uv = 1'b0;
  logic failover_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // reference state, built from the requirements
  int  ref_faults = 0;
  int  ref_goods  = 0;
  bit  ref_flag_n = 1'b1;

  always #5 clk = ~clk;

  failover_flag_ctl #(.RUN_LEN(3)) uut (
    .clk        (clk),
    .rst        (rst),
    .good_evt   (good_evt),
    .fault_evt  (fault_evt),
    .uv         (uv),
    .failover_n (failover_n)
  );

  function automatic void model_step(bit g, bit f, bit u, bit r);
    if (r || u) begin
      ref_faults = 0; ref_goods = 0; ref_flag_n = 1'b1;
    end else if (f) begin
      ref_goods = 0;
      if (ref_faults < 3) ref_faults++;
      if (ref_faults == 3) ref_flag_n = 1'b0;
    end else if (g) begin
      ref_faults = 0;
      if (ref_goods < 3) ref_goods++;
      if (ref_goods == 3) ref_flag_n = 1'b1;
    end
  endfunction

  task automatic check(string req, bit exp);
    n_checks++;
    if (failover_n !== exp) begin
      n_fails++;
      $display("FAIL %s: failover_n=%b expected %b at %0t", req, failover_n, exp, $time);
    end
  endtask

  // present inputs for one cycle (called at a falling edge), compare after
  task automatic cyc(bit g, bit f, bit u, string req);
    good_evt = g; fault_evt = f; uv = u;
    @(posedge clk);
    model_step(g, f, u, rst);
    @(negedge clk);
    good_evt = 1'b0; fault_evt = 1'b0; uv = 1'b0;
    check(req, ref_flag_n);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); model_step(0, 0, 0, 1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: run hung, got=%0d expected=%0d cycles", 100000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    @(negedge clk);
    do_reset();
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R1: failover_n=%b expected 1", failover_n); end

    // R2: three faults, low after the third
    cyc(0, 1, 0, "R2"); cyc(0, 1, 0, "R2");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R2: early assert %b expected 1", failover_n); end
    cyc(0, 1, 0, "R2");
    n_checks++; if (failover_n !== 1'b0) begin n_fails++; $display("FAIL R2: failover_n=%b expected 0", failover_n); end

    // R4: more faults keep it low; two goods not enough, third releases
    cyc(0, 1, 0, "R4"); cyc(0, 1, 0, "R4"); cyc(0, 0, 0, "R4");
    cyc(1, 0, 0, "R4"); cyc(1, 0, 0, "R4");
    n_checks++; if (failover_n !== 1'b0) begin n_fails++; $display("FAIL R4: early release %b expected 0", failover_n); end
    cyc(1, 0, 0, "R4");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R4: failover_n=%b expected 1", failover_n); end

    // R1: reset discards a partial fault run
    cyc(0, 1, 0, "R1"); cyc(0, 1, 0, "R1");
    do_reset();
    cyc(0, 1, 0, "R1");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R1: failover_n=%b expected 1", failover_n); end
    do_reset();

    // R3: good edge between faults
    cyc(0, 1, 0, "R3"); cyc(0, 1, 0, "R3"); cyc(1, 0, 0, "R3");
    cyc(0, 1, 0, "R3"); cyc(0, 1, 0, "R3");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R3: failover_n=%b expected 1", failover_n); end

    // R5: assert, then a fault breaks a good run
    cyc(0, 1, 0, "R5");
    cyc(1, 0, 0, "R5"); cyc(1, 0, 0, "R5"); cyc(0, 1, 0, "R5");
    cyc(1, 0, 0, "R5"); cyc(1, 0, 0, "R5");
    n_checks++; if (failover_n !== 1'b0) begin n_fails++; $display("FAIL R5: failover_n=%b expected 0", failover_n); end
    cyc(1, 0, 0, "R5");

    // R6/R7: undervoltage mid-run and while asserted
    cyc(0, 1, 0, "R6"); cyc(0, 1, 0, "R6"); cyc(0, 1, 1, "R6");
    cyc(0, 1, 0, "R6"); cyc(0, 1, 0, "R6");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R6: failover_n=%b expected 1", failover_n); end
    cyc(0, 1, 0, "R6");
    cyc(0, 1, 1, "R7");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R7: failover_n=%b expected 1", failover_n); end
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, "R7");

    // R8: tied strobes count as faults
    cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8"); cyc(1, 1, 0, "R8");
    n_checks++; if (failover_n !== 1'b0) begin n_fails++; $display("FAIL R8: failover_n=%b expected 0", failover_n); end

    // R9: long saturating runs
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R9");
    n_checks++; if (failover_n !== 1'b1) begin n_fails++; $display("FAIL R9: failover_n=%b expected 1", failover_n); end
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R9");
    n_checks++; if (failover_n !== 1'b0) begin n_fails++; $display("FAIL R9: failover_n=%b expected 0", failover_n); end

    // random mix, phases biased towards faults or goods
    for (int blk = 0; blk < 40; blk++) begin
      for (int i = 0; i < 64; i++) begin
        int pf;
        bit g, f, u;
        pf = blk[0] ? 6 : 2;
        f = ($urandom % 8) < pf;
        g = ($urandom % 8) < (8 - pf);
        u = ($urandom % 24) == 0;
        cyc(g, f, u, "R4");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule